// File: doc/BRIEF.md
# Task-File Configuration Gate

This block sits on the device side of a legacy parallel ATA channel. It watches the byte/word I/O bus that reaches the eight task-file offsets. Normally every access passes straight through to the task-file registers. A small bank of configuration registers is hidden behind the same offsets and opens only after a fixed access sequence. That sequence is two 16-bit reads of the error/feature offset, followed at once by a byte write of a key value to the sector-count offset. A byte write of a different key to that offset closes the bank again.

While the bank is open, it holds one read-cycle timing value and one write-cycle timing value per drive. It also holds a control register, a strap register and a miscellaneous register. The miscellaneous register selects the drive that later timing writes target, and it carries an address-setup field that both drives share.

Until the control register receives the override code, the timing outputs show defaults chosen by the bus-clock strap pin. Once the code arrives, a sticky override output goes high and the timing outputs show the programmed values.

Top module: `taskfile_cfg_gate`

## Requirements
- R1: After reset the gate is locked (`cfgMode` = 0) and `overrideStrap` = 0.
- R2: While locked, a read asserts `passRd` and a write asserts `passWr` in the same cycle. A write to offset 0 while locked leaves the programmed timing values unchanged.
- R3: A 16-bit read of offset 1, then another 16-bit read of offset 1, then a byte write of 0x03 to offset 2, each on consecutive accesses, sets `cfgMode` = 1 from the cycle after the write.
- R4: The gate stays locked if any other access comes between the arming reads and the key write. This covers a byte read of offset 1, an access to another offset, and a write of any value other than 0x03.
- R5: While `cfgMode` = 1, no access asserts `passRd` or `passWr`.
- R6: While open, a write to offset 0 loads the read timing of the selected drive, and a write to offset 1 loads its write timing. The selected drive is bit 0 of the miscellaneous register, which is at offset 6.
- R7: `addrSetup` equals bits 5:4 of the miscellaneous register, and one value serves both drives.
- R8: While open, a read of offset 5 asserts `cfgRdHit`. `busRdata` is 0 unless the strap register (offset 5) holds 0xFF; in that case bit 0 of `busRdata` equals `clkStrap` and all other bits are 0.
- R9: A write of 0x85 to the control register (offset 3) sets `overrideStrap`, which then stays high. A write of any other value to that register leaves it low.
- R10: While open, a byte write of 0x83 to offset 2 clears `cfgMode` from the next cycle.
- R11: While `overrideStrap` = 0, every timing output equals DEF_SLOW (0x7F) when `clkStrap` = 0 and DEF_FAST (0x5A) when `clkStrap` = 1. Once `overrideStrap` = 1, the outputs show the programmed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Task-file offset |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWide | input | 1 | 1 = 16-bit access, 0 = byte access |
| busWdata | input | 8 | Write data byte |
| clkStrap | input | 1 | Bus-clock strap, 1 = fast clock |
| busRdata | output | 16 | Configuration read data, valid with cfgRdHit |
| cfgRdHit | output | 1 | The gate answers the current read |
| passRd | output | 1 | Read forwarded to the task file |
| passWr | output | 1 | Write forwarded to the task file |
| cfgMode | output | 1 | Configuration bank open |
| overrideStrap | output | 1 | Programmed timings in force |
| rdTimings | output | 16 | Effective read timing, drive 0 in bits 7:0 |
| wrTimings | output | 16 | Effective write timing, drive 0 in bits 7:0 |
| addrSetup | output | 2 | Shared address-setup field |

## Verification
The outputs `passRd`, `passWr`, `cfgRdHit` and `busRdata` are combinational and belong to the access in flight. The bench therefore samples them one time unit after it drives a strobe, which is still before the clock edge. Sequence state, register loads and the override flag each pass through one register, so they are due in the cycle after the access. The bench checks them one time unit after the edge that took the strobe, once that strobe has dropped. `clkStrap` flows combinationally into the defaults and the strap read, so the bench checks its effect without waiting for a clock edge.

// File: rtl/trapdoor_pkg.sv
package trapdoor_pkg;
  localparam logic [2:0] OFS_RD_TIM = 3'd0;
  localparam logic [2:0] OFS_ERR    = 3'd1;
  localparam logic [2:0] OFS_WR_TIM = 3'd1;
  localparam logic [2:0] OFS_GATE   = 3'd2;
  localparam logic [2:0] OFS_CTRL   = 3'd3;
  localparam logic [2:0] OFS_STRAP  = 3'd5;
  localparam logic [2:0] OFS_MISC   = 3'd6;
  localparam logic [7:0] KEY_OPEN   = 8'h03;
  localparam logic [7:0] KEY_CLOSE  = 8'h83;
  localparam logic [7:0] CODE_OVR   = 8'h85;
  localparam logic [7:0] STRAP_ARM  = 8'hFF;

  typedef enum logic [1:0] {SeqIdle, SeqArm1, SeqArm2, SeqCfg} seqState_t;

  typedef struct packed {
    logic       active;
    logic       wrRdTim;
    logic       wrWrTim;
    logic       wrCtrl;
    logic       wrStrap;
    logic       wrMisc;
    logic [7:0] data;
  } cfgStrobe_t;
endpackage

// File: rtl/trapdoor_ctrl.sv
module trapdoor_ctrl
  import trapdoor_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] busAddr,
  input  logic       busRd,
  input  logic       busWr,
  input  logic       busWide,
  input  logic [7:0] busWdata,
  output cfgStrobe_t strb,
  output logic       cfgRdHit,
  output logic       passRd,
  output logic       passWr,
  output logic       cfgMode
);
  seqState_t state, stateNext;
  logic anyAccess, armRead, keyOpen, keyClose, inCfg;

  assign anyAccess = busRd | busWr;
  assign armRead   = busRd & busWide & (busAddr == OFS_ERR);
  assign keyOpen   = busWr & ~busWide & (busAddr == OFS_GATE) & (busWdata == KEY_OPEN);
  assign keyClose  = busWr & ~busWide & (busAddr == OFS_GATE) & (busWdata == KEY_CLOSE);
  assign inCfg     = (state == SeqCfg);

  always_comb begin
    stateNext = state;
    case (state)
      SeqIdle: if (armRead) stateNext = SeqArm1;
      SeqArm1: if (anyAccess) stateNext = armRead ? SeqArm2 : SeqIdle;
      SeqArm2: if (anyAccess) stateNext = keyOpen ? SeqCfg : SeqIdle;
      SeqCfg:  if (keyClose) stateNext = SeqIdle;
      default: stateNext = SeqIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SeqIdle;
    else       state <= stateNext;
  end

  always_comb begin
    strb.active  = inCfg;
    strb.wrRdTim = inCfg & busWr & (busAddr == OFS_RD_TIM);
    strb.wrWrTim = inCfg & busWr & (busAddr == OFS_WR_TIM);
    strb.wrCtrl  = inCfg & busWr & (busAddr == OFS_CTRL);
    strb.wrStrap = inCfg & busWr & (busAddr == OFS_STRAP);
    strb.wrMisc  = inCfg & busWr & (busAddr == OFS_MISC);
    strb.data    = busWdata;
  end

  assign cfgRdHit = inCfg & busRd & (busAddr == OFS_STRAP);
  assign passRd   = busRd & ~inCfg;
  assign passWr   = busWr & ~inCfg;
  assign cfgMode  = inCfg;

  // R3: the key write after two arming reads opens the bank
  p_unlock_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == SeqArm2 && keyOpen) |=> cfgMode);

  // R4: the bank opens only on the cycle after a key write
  p_enter_key_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgMode) |-> $past(keyOpen));

  // R10: the close key relocks
  p_relock_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode && keyClose) |=> !cfgMode);
endmodule

// File: rtl/trapdoor_regs.sv
module trapdoor_regs
  import trapdoor_pkg::*;
#(
  parameter int         DRIVES   = 2,
  parameter logic [7:0] DEF_SLOW = 8'h7F,
  parameter logic [7:0] DEF_FAST = 8'h5A
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgStrobe_t            strb,
  input  logic                  clkStrap,
  output logic [15:0]           cfgRdata,
  output logic                  overrideStrap,
  output logic [DRIVES*8-1:0]   rdTimings,
  output logic [DRIVES*8-1:0]   wrTimings,
  output logic [1:0]            addrSetup
);
  localparam int SEL_W = (DRIVES > 1) ? $clog2(DRIVES) : 1;

  logic [DRIVES-1:0][7:0] rdTim, wrTim;
  logic [7:0] strapReg, miscReg;
  logic [SEL_W-1:0] driveSel;
  logic overrideQ;
  logic [7:0] defTiming;

  assign driveSel  = miscReg[SEL_W-1:0];
  assign defTiming = clkStrap ? DEF_FAST : DEF_SLOW;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdTim     <= '0;
      wrTim     <= '0;
      strapReg  <= '0;
      miscReg   <= '0;
      overrideQ <= 1'b0;
    end else begin
      if (strb.wrRdTim) rdTim[driveSel] <= strb.data;
      if (strb.wrWrTim) wrTim[driveSel] <= strb.data;
      if (strb.wrStrap) strapReg <= strb.data;
      if (strb.wrMisc)  miscReg  <= strb.data;
      if (strb.wrCtrl && strb.data == CODE_OVR) overrideQ <= 1'b1;
    end
  end

  for (genvar d = 0; d < DRIVES; d++) begin : g_drive
    assign rdTimings[d*8 +: 8] = overrideQ ? rdTim[d] : defTiming;
    assign wrTimings[d*8 +: 8] = overrideQ ? wrTim[d] : defTiming;
  end

  assign cfgRdata      = (strapReg == STRAP_ARM) ? {15'd0, clkStrap} : 16'd0;
  assign overrideStrap = overrideQ;
  assign addrSetup     = miscReg[5:4];

  // R2: while the bank is locked, timing storage holds
  p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |=> ($stable(rdTim) && $stable(wrTim)));

  // R9: override is sticky
  p_override_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overrideStrap |=> overrideStrap);
endmodule

// File: rtl/taskfile_cfg_gate.sv
module taskfile_cfg_gate
  import trapdoor_pkg::*;
#(
  parameter int         DRIVES   = 2,
  parameter logic [7:0] DEF_SLOW = 8'h7F,
  parameter logic [7:0] DEF_FAST = 8'h5A
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          busAddr,
  input  logic                busRd,
  input  logic                busWr,
  input  logic                busWide,
  input  logic [7:0]          busWdata,
  input  logic                clkStrap,
  output logic [15:0]         busRdata,
  output logic                cfgRdHit,
  output logic                passRd,
  output logic                passWr,
  output logic                cfgMode,
  output logic                overrideStrap,
  output logic [DRIVES*8-1:0] rdTimings,
  output logic [DRIVES*8-1:0] wrTimings,
  output logic [1:0]          addrSetup
);
  cfgStrobe_t strb;

  trapdoor_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWide(busWide), .busWdata(busWdata), .strb(strb), .cfgRdHit(cfgRdHit),
    .passRd(passRd), .passWr(passWr), .cfgMode(cfgMode)
  );

  trapdoor_regs #(.DRIVES(DRIVES), .DEF_SLOW(DEF_SLOW), .DEF_FAST(DEF_FAST)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .clkStrap(clkStrap), .cfgRdata(busRdata),
    .overrideStrap(overrideStrap), .rdTimings(rdTimings), .wrTimings(wrTimings),
    .addrSetup(addrSetup)
  );
endmodule

// File: tb/taskfile_cfg_gate_tb.sv
module taskfile_cfg_gate_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic busRd = 1'b0, busWr = 1'b0, busWide = 1'b0;
  logic [7:0] busWdata = '0;
  logic clkStrap = 1'b0;
  logic [15:0] busRdata;
  logic cfgRdHit, passRd, passWr, cfgMode, overrideStrap;
  logic [15:0] rdTimings, wrTimings;
  logic [1:0] addrSetup;

  int nChecks = 0;
  int nFails = 0;
  logic sPassRd, sPassWr, sHit;
  logic [15:0] sRdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  taskfile_cfg_gate u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWide(busWide), .busWdata(busWdata), .clkStrap(clkStrap), .busRdata(busRdata),
    .cfgRdHit(cfgRdHit), .passRd(passRd), .passWr(passWr), .cfgMode(cfgMode),
    .overrideStrap(overrideStrap), .rdTimings(rdTimings), .wrTimings(wrTimings),
    .addrSetup(addrSetup)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access; combinational outputs captured before the edge, registers settled after it
  task automatic access(input logic [2:0] a, input logic wr, input logic wide, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWr = wr; busRd = ~wr; busWide = wide; busWdata = d;
    #1;
    sPassRd = passRd; sPassWr = passWr; sHit = cfgRdHit; sRdata = busRdata;
    @(posedge clk);
    #1;
    busRd = 1'b0; busWr = 1'b0;
  endtask

  task automatic unlock();
    access(3'd1, 1'b0, 1'b1, 8'h00);
    access(3'd1, 1'b0, 1'b1, 8'h00);
    access(3'd2, 1'b1, 1'b0, 8'h03);
  endtask

  task automatic t_reset();
    check("R1 cfgMode", {15'd0, cfgMode}, 16'd0);
    check("R1 override", {15'd0, overrideStrap}, 16'd0);
    check("R11 slow rd", rdTimings, 16'h7F7F);
    clkStrap = 1'b1; #1;
    check("R11 fast wr", wrTimings, 16'h5A5A);
    clkStrap = 1'b0; #1;
  endtask

  task automatic t_unlock();
    access(3'd1, 1'b0, 1'b1, 8'h00);
    check("R2 passRd locked", {15'd0, sPassRd}, 16'd1);
    access(3'd1, 1'b0, 1'b1, 8'h00);
    access(3'd2, 1'b1, 1'b0, 8'h03);
    check("R2 passWr locked", {15'd0, sPassWr}, 16'd1);
    check("R3 unlocked", {15'd0, cfgMode}, 16'd1);
    access(3'd4, 1'b0, 1'b0, 8'h00);
    check("R5 no passRd", {15'd0, sPassRd}, 16'd0);
    access(3'd7, 1'b1, 1'b0, 8'h11);
    check("R5 no passWr", {15'd0, sPassWr}, 16'd0);
    access(3'd2, 1'b1, 1'b0, 8'h83);
    check("R10 relocked", {15'd0, cfgMode}, 16'd0);
  endtask

  task automatic t_broken();
    access(3'd1, 1'b0, 1'b1, 8'h00);
    access(3'd1, 1'b0, 1'b1, 8'h00);
    access(3'd7, 1'b0, 1'b0, 8'h00);
    access(3'd2, 1'b1, 1'b0, 8'h03);
    check("R4 intervening access", {15'd0, cfgMode}, 16'd0);
    access(3'd1, 1'b0, 1'b1, 8'h00);
    access(3'd2, 1'b1, 1'b0, 8'h03);
    check("R4 single read", {15'd0, cfgMode}, 16'd0);
    access(3'd1, 1'b0, 1'b0, 8'h00);
    access(3'd1, 1'b0, 1'b0, 8'h00);
    access(3'd2, 1'b1, 1'b0, 8'h03);
    check("R4 byte reads", {15'd0, cfgMode}, 16'd0);
    access(3'd1, 1'b0, 1'b1, 8'h00);
    access(3'd1, 1'b0, 1'b1, 8'h00);
    access(3'd2, 1'b1, 1'b0, 8'h04);
    check("R4 wrong key", {15'd0, cfgMode}, 16'd0);
  endtask

  task automatic t_strap();
    unlock();
    access(3'd5, 1'b0, 1'b1, 8'h00);
    check("R8 hit", {15'd0, sHit}, 16'd1);
    check("R8 unarmed data", sRdata, 16'd0);
    access(3'd5, 1'b1, 1'b0, 8'hFF);
    clkStrap = 1'b1;
    access(3'd5, 1'b0, 1'b1, 8'h00);
    check("R8 strap one", sRdata, 16'd1);
    clkStrap = 1'b0;
    access(3'd5, 1'b0, 1'b1, 8'h00);
    check("R8 strap zero", sRdata, 16'd0);
  endtask

  task automatic t_program();
    access(3'd6, 1'b1, 1'b0, 8'h00);
    access(3'd0, 1'b1, 1'b0, 8'h41);
    access(3'd1, 1'b1, 1'b0, 8'h42);
    access(3'd6, 1'b1, 1'b0, 8'h01);
    access(3'd0, 1'b1, 1'b0, 8'h51);
    access(3'd1, 1'b1, 1'b0, 8'h52);
    access(3'd6, 1'b1, 1'b0, 8'h20);
    check("R11 defaults before override", rdTimings, 16'h7F7F);
    check("R7 addrSetup", {14'd0, addrSetup}, 16'd2);
    access(3'd3, 1'b1, 1'b0, 8'h12);
    check("R9 other code", {15'd0, overrideStrap}, 16'd0);
    access(3'd3, 1'b1, 1'b0, 8'h85);
    check("R9 override set", {15'd0, overrideStrap}, 16'd1);
    check("R6 rd timings", rdTimings, 16'h5141);
    check("R6 wr timings", wrTimings, 16'h5242);
    access(3'd6, 1'b1, 1'b0, 8'h30);
    check("R7 addrSetup update", {14'd0, addrSetup}, 16'd3);
  endtask

  task automatic t_relock();
    access(3'd2, 1'b1, 1'b0, 8'h83);
    check("R10 relock", {15'd0, cfgMode}, 16'd0);
    access(3'd0, 1'b1, 1'b0, 8'h99);
    check("R2 locked write passes", {15'd0, sPassWr}, 16'd1);
    check("R2 timing unchanged", rdTimings, 16'h5141);
    access(3'd3, 1'b1, 1'b0, 8'h00);
    check("R9 sticky", {15'd0, overrideStrap}, 16'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_unlock();
    t_broken();
    t_strap();
    t_program();
    t_relock();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule